// File: doc/BRIEF.md
# Compare Timer with Watchdog Channel

This block is a timer for a larger chip. It has a 32-bit counter that counts up by one on every tick strobe it receives, and a bank of 32-bit compare channels. When the counter value present in a tick cycle equals a channel's compare value, that channel sets a sticky pending flag. Pending flags that are enabled drive a single interrupt line. Software reaches everything through a small register bus with byte offsets. The bus has a write strobe and a combinational read path.

One compare channel can also act as a watchdog. There is no separate down-counter. Software takes an atomic snapshot of the counter through a capture register, adds a timeout in ticks, and writes the sum to the watchdog channel's compare register as an absolute deadline. The ticks left are always the deadline minus the live counter, modulo 2^32. If the counter reaches the deadline while watchdog mode is armed and that channel's interrupt enable is set, the block drives a system reset pulse of fixed length and then disarms watchdog mode.

Top module: `tmr_wdog_top`

## Requirements
- R1: After reset the counter, all compare registers, the capture register, the pending flags, the interrupt enables and watchdog mode are zero, and `irq_o` and `wdt_rst_o` are low.
- R2: The counter at offset 0x00 advances by exactly one at each clock edge where `tick_i` is high and holds otherwise; writes to 0x00 are ignored.
- R3: Compare register n is read and written at offset 0x08 + 4·n, for n from 0 to NUM_CH-1 (default 6 channels).
- R4: A channel matches in a cycle where `tick_i` is high and the counter equals its compare value; the match sets bit n of the pending register at offset 0x20 at that clock edge, and the bit stays set until cleared.
- R5: Writing 0x20 clears each pending bit written as 1 and leaves bits written as 0; a match in the same cycle as the clear leaves the bit set.
- R6: Interrupt enable at offset 0x24 holds one bit per channel (bit n for channel n, upper bits read 0); `irq_o` is high while any pending bit has its enable bit set.
- R7: Writing a value with bit 0 set to offset 0x30 copies the counter of that cycle into the capture register at 0x34; a write with bit 0 clear captures nothing, and the captured value stays unchanged as the counter moves on.
- R8: Watchdog mode is bit 0 of offset 0x28, readable and writable.
- R9: When channel 5 matches while watchdog mode is on and enable bit 5 is set, `wdt_rst_o` goes high from the next cycle for exactly 16 consecutive cycles.
- R10: A match on channel 5 with enable bit 5 clear gives no reset pulse, though its pending bit is still set and watchdog mode stays on.
- R11: When the reset pulse ends, watchdog mode reads back 0.
- R12: Writing a later deadline to channel 5 before the counter reaches the old one prevents the reset at the old deadline.
- R13: Reads from unmapped offsets (for example 0x2C and the write-only 0x30) return 0, and the two low address bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Counter advance strobe, one tick per high cycle |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | ADDR_W (6) | Register byte offset |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i`, combinational |
| irq_o | output | 1 | Any enabled pending flag |
| wdt_rst_o | output | 1 | Watchdog system reset pulse |

## Verification
The bench lines up a match and a pending clear in the same cycle. A design that lets the clear win would lose the event. It checks the exact cycle at which the reset rises, by reading the counter there, and the exact pulse length. An off-by-one in the pulse counter or an extra register would show up as a wrong count or a wrong counter value. It moves the watchdog deadline out before the counter reaches it. A design that latched the old compare value, or compared only against its first write, would fire anyway. It also runs a match with the watchdog enable bit clear. A design that ignored the enable gating would reset the system even though the pending flag alone should be the only effect.

// File: rtl/tmr_wdog_pkg.sv
package tmr_wdog_pkg;

  localparam int DATA_W = 32;

  // Register byte offsets; compare registers are laid out per channel
  localparam int OFS_COUNT   = 'h00;
  localparam int OFS_MATCH0  = 'h08;
  localparam int OFS_STATUS  = 'h20;
  localparam int OFS_INTEN   = 'h24;
  localparam int OFS_WDEN    = 'h28;
  localparam int OFS_LATCH   = 'h30;
  localparam int OFS_LATCHED = 'h34;

  // Ticks remaining until a deadline, wrap-around safe
  function automatic logic [DATA_W-1:0] ticks_left(input logic [DATA_W-1:0] due,
                                                   input logic [DATA_W-1:0] now);
    return due - now;
  endfunction

  // Byte offset of the compare register of a channel
  function automatic int match_ofs(input int ch);
    return OFS_MATCH0 + 4 * ch;
  endfunction

endpackage

// File: rtl/tmr_free_counter.sv
module tmr_free_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_i,
  output logic [W-1:0] cnt_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_q + W'(1);
  end

  assign cnt_o = cnt_q;

  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i |=> (cnt_q == $past(cnt_q) + W'(1)));

  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(cnt_q));

endmodule

// File: rtl/tmr_match_bank.sv
module tmr_match_bank import tmr_wdog_pkg::*; #(
  parameter int NUM_CH = 6,
  parameter int W      = DATA_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     tick_i,
  input  logic [W-1:0]             cnt_i,
  input  logic [NUM_CH-1:0]        wr_en_i,
  input  logic [W-1:0]             wdata_i,
  input  logic                     clr_en_i,
  input  logic [NUM_CH-1:0]        clr_mask_i,
  output logic [NUM_CH-1:0][W-1:0] match_o,
  output logic [NUM_CH-1:0]        hit_o,
  output logic [NUM_CH-1:0]        pend_o
);

  logic [NUM_CH-1:0][W-1:0] match_q;
  logic [NUM_CH-1:0]        pend_q;
  logic [NUM_CH-1:0]        hit;

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          match_q[n] <= '0;
      else if (wr_en_i[n]) match_q[n] <= wdata_i;
    end

    assign hit[n] = tick_i && (ticks_left(match_q[n], cnt_i) == '0);

    // Set has priority over a software clear in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         pend_q[n] <= 1'b0;
      else if (hit[n])                    pend_q[n] <= 1'b1;
      else if (clr_en_i && clr_mask_i[n]) pend_q[n] <= 1'b0;
    end

    // R4
    hit_sets_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit[n] |=> pend_q[n]);

    // R4
    pend_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q[n] && !(clr_en_i && clr_mask_i[n])) |=> pend_q[n]);

    // R5
    pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_en_i && clr_mask_i[n] && !hit[n]) |=> !pend_q[n]);
  end

  assign match_o = match_q;
  assign hit_o   = hit;
  assign pend_o  = pend_q;

endmodule

// File: rtl/tmr_rst_pulse.sv
module tmr_rst_pulse #(
  parameter int LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire_i,
  output logic rst_o,
  output logic done_o
);

  localparam int CW = $clog2(LEN + 1);

  logic [CW-1:0] left_q;
  logic          busy;

  assign busy = (left_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               left_q <= '0;
    else if (fire_i && !busy) left_q <= CW'(LEN);
    else if (busy)            left_q <= left_q - CW'(1);
  end

  assign rst_o  = busy;
  assign done_o = (left_q == CW'(1));

  // Checker-side length counter
  logic [CW-1:0] len_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     len_q <= '0;
    else if (rst_o) len_q <= len_q + CW'(1);
    else            len_q <= '0;
  end

  // R9
  rst_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_i && !rst_o) |=> rst_o);

  // R9
  rst_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_o) |-> (len_q == CW'(LEN)));

  // R9
  rst_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    len_q <= CW'(LEN));

endmodule

// File: rtl/tmr_wdog_top.sv
module tmr_wdog_top import tmr_wdog_pkg::*; #(
  parameter int NUM_CH  = 6,
  parameter int WDOG_CH = 5,
  parameter int RST_LEN = 16,
  parameter int ADDR_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              irq_o,
  output logic              wdt_rst_o
);

  localparam int WIDX_W = ADDR_W - 2;
  localparam logic [WIDX_W-1:0] W_COUNT   = WIDX_W'(OFS_COUNT / 4);
  localparam logic [WIDX_W-1:0] W_STATUS  = WIDX_W'(OFS_STATUS / 4);
  localparam logic [WIDX_W-1:0] W_INTEN   = WIDX_W'(OFS_INTEN / 4);
  localparam logic [WIDX_W-1:0] W_WDEN    = WIDX_W'(OFS_WDEN / 4);
  localparam logic [WIDX_W-1:0] W_LATCH   = WIDX_W'(OFS_LATCH / 4);
  localparam logic [WIDX_W-1:0] W_LATCHED = WIDX_W'(OFS_LATCHED / 4);

  logic [WIDX_W-1:0] widx;
  logic              unused_lo;
  assign widx      = bus_addr_i[ADDR_W-1:2];
  assign unused_lo = ^bus_addr_i[1:0];

  // Write decodes
  logic              wr_status, wr_inten, wr_wden, wr_latch;
  logic [NUM_CH-1:0] wr_match;
  assign wr_status = bus_wr_i && (widx == W_STATUS);
  assign wr_inten  = bus_wr_i && (widx == W_INTEN);
  assign wr_wden   = bus_wr_i && (widx == W_WDEN);
  assign wr_latch  = bus_wr_i && (widx == W_LATCH) && bus_wdata_i[0];

  for (genvar n = 0; n < NUM_CH; n++) begin : g_wdec
    assign wr_match[n] = bus_wr_i && (widx == WIDX_W'(match_ofs(n) / 4));
  end

  // Submodules
  logic [DATA_W-1:0]             cnt;
  logic [NUM_CH-1:0][DATA_W-1:0] match;
  logic [NUM_CH-1:0]             hit;
  logic [NUM_CH-1:0]             pend;
  logic                          wd_fire;
  logic                          pulse_done;

  tmr_free_counter #(.W(DATA_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_i (tick_i),
    .cnt_o  (cnt)
  );

  tmr_match_bank #(.NUM_CH(NUM_CH), .W(DATA_W)) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (tick_i),
    .cnt_i      (cnt),
    .wr_en_i    (wr_match),
    .wdata_i    (bus_wdata_i),
    .clr_en_i   (wr_status),
    .clr_mask_i (bus_wdata_i[NUM_CH-1:0]),
    .match_o    (match),
    .hit_o      (hit),
    .pend_o     (pend)
  );

  // Control registers
  logic [NUM_CH-1:0] inten_q;
  logic              wden_q;
  logic [DATA_W-1:0] latched_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        inten_q <= '0;
    else if (wr_inten) inten_q <= bus_wdata_i[NUM_CH-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          wden_q <= 1'b0;
    else if (pulse_done) wden_q <= 1'b0;
    else if (wr_wden)    wden_q <= bus_wdata_i[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        latched_q <= '0;
    else if (wr_latch) latched_q <= cnt;
  end

  // Watchdog reset path
  assign wd_fire = hit[WDOG_CH] && wden_q && inten_q[WDOG_CH];

  tmr_rst_pulse #(.LEN(RST_LEN)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .fire_i (wd_fire),
    .rst_o  (wdt_rst_o),
    .done_o (pulse_done)
  );

  assign irq_o = |(pend & inten_q);

  // Read mux
  always_comb begin
    bus_rdata_o = '0;
    if (widx == W_COUNT)   bus_rdata_o = cnt;
    if (widx == W_STATUS)  bus_rdata_o = DATA_W'(pend);
    if (widx == W_INTEN)   bus_rdata_o = DATA_W'(inten_q);
    if (widx == W_WDEN)    bus_rdata_o = DATA_W'(wden_q);
    if (widx == W_LATCHED) bus_rdata_o = latched_q;
    for (int n = 0; n < NUM_CH; n++) begin
      if (widx == WIDX_W'(match_ofs(n) / 4)) bus_rdata_o = match[n];
    end
  end

  // R9 R10
  rst_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wdt_rst_o) |-> $past(hit[WDOG_CH] && wden_q && inten_q[WDOG_CH]));

  // R11
  wden_autoclear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_done |=> !wden_q);

  // R7
  latch_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_latch |=> $stable(latched_q));

  // R7
  latch_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_latch |=> (latched_q == $past(cnt)));

  // R6
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ((pend & inten_q) != '0));

endmodule

// File: tb/tmr_wdog_top_tb.sv
module tmr_wdog_top_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick_i;
  logic        bus_wr_i;
  logic [5:0]  bus_addr_i;
  logic [31:0] bus_wdata_i;
  logic [31:0] bus_rdata_o;
  logic        irq_o;
  logic        wdt_rst_o;

  always #(CLK_PERIOD / 2) clk = ~clk;

  tmr_wdog_top dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (tick_i),
    .bus_wr_i    (bus_wr_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_rdata_o (bus_rdata_o),
    .irq_o       (irq_o),
    .wdt_rst_o   (wdt_rst_o)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  typedef struct packed {
    logic        wr;
    logic [7:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int VEC_N = 14;
  localparam vec_t VECS [VEC_N] = '{
    '{1'b1, 8'h08, 32'h1111_1111, 32'h0, 8'd3},         // R3 write ch0
    '{1'b1, 8'h1C, 32'hDEAD_BEEF, 32'h0, 8'd3},         // R3 write ch5
    '{1'b1, 8'h24, 32'hFFFF_FFFF, 32'h0, 8'd6},         // R6 enables
    '{1'b1, 8'h28, 32'h0000_0001, 32'h0, 8'd8},         // R8 arm
    '{1'b1, 8'h00, 32'h0000_5555, 32'h0, 8'd2},         // R2 ignored write
    '{1'b0, 8'h08, 32'h0, 32'h1111_1111, 8'd3},         // R3
    '{1'b0, 8'h1C, 32'h0, 32'hDEAD_BEEF, 8'd3},         // R3
    '{1'b0, 8'h0C, 32'h0, 32'h0000_0000, 8'd3},         // R3 untouched ch1
    '{1'b0, 8'h24, 32'h0, 32'h0000_003F, 8'd6},         // R6 upper bits 0
    '{1'b0, 8'h28, 32'h0, 32'h0000_0001, 8'd8},         // R8
    '{1'b0, 8'h00, 32'h0, 32'h0000_0000, 8'd2},         // R2
    '{1'b0, 8'h2C, 32'h0, 32'h0000_0000, 8'd13},        // R13 unmapped
    '{1'b0, 8'h30, 32'h0, 32'h0000_0000, 8'd13},        // R13 write-only
    '{1'b0, 8'h1F, 32'h0, 32'hDEAD_BEEF, 8'd13}         // R13 low bits
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; tick_i = 1'b0; bus_wr_i = 1'b0; bus_addr_i = '0; bus_wdata_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr_i = 1'b1; bus_addr_i = a[5:0]; bus_wdata_i = d;
    @(negedge clk);
    bus_wr_i = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr_i = a[5:0];
    #1 d = bus_rdata_o;
  endtask

  // Ticks n cycles while watching the counter and the reset output
  task automatic run_ticks(input int n, output int hi, output int rises,
                           output logic [31:0] first_cnt);
    logic prev;
    hi = 0; rises = 0; first_cnt = '1; prev = 1'b0;
    @(negedge clk);
    bus_addr_i = 6'h00; tick_i = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (wdt_rst_o) begin
        hi++;
        if (!prev) begin rises++; if (rises == 1) first_cnt = bus_rdata_o; end
      end
      prev = wdt_rst_o;
    end
    tick_i = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog (all requirements) actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int hi, rises;
    logic [31:0] fc;

    do_reset();

    // R1 reset state
    rd(8'h00, v); chk("R1 counter", v, 32'h0);
    rd(8'h08, v); chk("R1 match0", v, 32'h0);
    rd(8'h20, v); chk("R1 pending", v, 32'h0);
    rd(8'h24, v); chk("R1 inten", v, 32'h0);
    rd(8'h28, v); chk("R1 wden", v, 32'h0);
    rd(8'h34, v); chk("R1 latched", v, 32'h0);
    chk("R1 irq", {31'b0, irq_o}, 32'h0);
    chk("R1 rst", {31'b0, wdt_rst_o}, 32'h0);

    // Vector table, no ticks
    for (int k = 0; k < VEC_N; k++) begin
      if (VECS[k].wr) wr(VECS[k].addr, VECS[k].data);
      else begin
        rd(VECS[k].addr, v);
        chk($sformatf("R%0d table[%0d]", VECS[k].req, k), v, VECS[k].exp);
      end
    end

    do_reset();

    // R2 counting and holding
    run_ticks(7, hi, rises, fc);
    rd(8'h00, v); chk("R2 after 7 ticks", v, 32'd7);
    repeat (3) @(negedge clk);
    rd(8'h00, v); chk("R2 hold without tick", v, 32'd7);

    // R7 capture and stability
    wr(8'h30, 32'h1);
    run_ticks(5, hi, rises, fc);
    rd(8'h34, v); chk("R7 captured stays", v, 32'd7);
    wr(8'h30, 32'h0);
    rd(8'h34, v); chk("R7 bit0 clear no capture", v, 32'd7);
    wr(8'h30, 32'h1);
    rd(8'h34, v); chk("R7 recapture", v, 32'd12);

    // R4 all channels hit at count 0 (compare values 0)
    rd(8'h20, v); chk("R4 pending all", v, 32'h3F);
    chk("R6 irq masked", {31'b0, irq_o}, 32'h0);
    wr(8'h24, 32'h1);
    #1 chk("R6 irq enabled", {31'b0, irq_o}, 32'h1);
    wr(8'h20, 32'h1);
    rd(8'h20, v); chk("R5 w1c bit0", v, 32'h3E);
    chk("R6 irq after clear", {31'b0, irq_o}, 32'h0);
    wr(8'h20, 32'h0);
    rd(8'h20, v); chk("R5 write zero keeps", v, 32'h3E);
    wr(8'h20, 32'h3F);
    rd(8'h20, v); chk("R5 clear all", v, 32'h0);

    // R5 set beats clear in the same cycle (counter is 12)
    wr(8'h08, 32'd12);
    @(negedge clk);
    tick_i = 1'b1; bus_wr_i = 1'b1; bus_addr_i = 6'h20; bus_wdata_i = 32'h1;
    @(negedge clk);
    tick_i = 1'b0; bus_wr_i = 1'b0;
    rd(8'h20, v); chk("R5 set wins over clear", v, 32'h1);
    run_ticks(3, hi, rises, fc);
    rd(8'h20, v); chk("R4 sticky", v, 32'h1);

    // R10 match without enable bit 5
    do_reset();
    wr(8'h1C, 32'd10);
    wr(8'h28, 32'h1);
    run_ticks(30, hi, rises, fc);
    chk("R10 no reset pulse", hi, 32'd0);
    rd(8'h20, v); chk("R10 pending bit5", v & 32'h20, 32'h20);
    rd(8'h28, v); chk("R10 wden kept", v, 32'h1);

    // R12 refresh moves the deadline
    do_reset();
    wr(8'h1C, 32'd30);
    wr(8'h24, 32'h20);
    wr(8'h28, 32'h1);
    run_ticks(20, hi, rises, fc);
    wr(8'h30, 32'h1);
    rd(8'h34, v); chk("R7 snapshot", v, 32'd20);
    wr(8'h1C, v + 32'd30);
    run_ticks(25, hi, rises, fc);
    chk("R12 no reset at old deadline", hi, 32'd0);
    rd(8'h20, v); chk("R12 no pending bit5", v & 32'h20, 32'h0);

    // R9 R11 deadline 50 reached, counter now 45
    run_ticks(40, hi, rises, fc);
    chk("R9 pulse length", hi, 32'd16);
    chk("R9 single pulse", rises, 32'd1);
    chk("R9 rise cycle counter", fc, 32'd51);
    rd(8'h28, v); chk("R11 wden cleared", v, 32'h0);
    rd(8'h20, v); chk("R4 pending bit5", v & 32'h20, 32'h20);
    chk("R9 reset low after", {31'b0, wdt_rst_o}, 32'h0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule